// File: doc/BRIEF.md
# Iterated SHA-256 Hash Chain Engine

This block builds sequential hash chains: a 256-bit seed is hashed with SHA-256, the 256-bit digest is hashed again, and so on for a programmed number of rounds. Only the final value of each chain is kept. A job can hold many independent chains. Their seeds sit back to back in an input buffer, and their results are laid out the same way in a separate output buffer. Both buffers are reached through a simple word-addressed memory port. Each memory word is 32 bits. A read returns its data in the cycle after the request.

The host polls the status word until the engine is idle. It then writes four parameters: input base, output base, chain count and iteration count. Writing a 1 to bit 0 of the control word starts the job. The engine loads a chain's seed, runs the iterations through a one-round-per-clock compression datapath and stores the digest. It then moves on to the next chain. When every chain has been stored it sits in DONE until the host writes the control word again.

The control state machine has seven states. S_IDLE waits for a start. S_FETCH issues one seed read and S_LATCH captures the returned word; the pair repeats eight times. S_KICK launches one hash and S_HASH waits for its digest. S_STORE writes the eight result words. S_DONE waits for acknowledge. The transitions are:
- S_IDLE goes to S_FETCH on start, or to S_DONE when the chain count is zero.
- S_LATCH goes back to S_FETCH until eight words are in. It then goes to S_KICK, or straight to S_STORE for an iteration count of zero.
- S_HASH goes back to S_KICK until the last iteration is done, then to S_STORE.
- S_STORE goes to S_FETCH for the next chain, or to S_DONE after the last chain.
- S_DONE goes to S_IDLE on any write to the control word.

The hash core has three states: C_IDLE, C_ROUND for 64 cycles, and C_FINAL for the feed-forward addition.

Top module: `hash_chain_engine`

## Requirements
- R1: After reset the status word (register 0) reads 1 (bit 0 idle, bit 1 busy, bit 2 done), every parameter register reads 0, and mem_req is low.
- R2: The parameter registers sit at word addresses 1 (input base), 2 (output base), 3 (chain count) and 4 (iteration count). They read back what was written while idle. Writes to them while not idle are ignored.
- R3: Writing register 0 with bit 0 set while idle starts a job: the status then reads busy (2). A write of 0 to register 0 while idle, or any start while busy, starts nothing.
- R4: The seed of chain k is read from input base + 8k through + 8k + 7. The first word is the most significant 32 bits of the 256-bit value, so it is the first four message bytes in big-endian order.
- R5: Each iteration is a standard SHA-256 over exactly 32 bytes: one 512-bit block holding the value, then 0x80000000, six zero words and a length word of 256. Each iteration starts from the standard initial hash values. The result is the chain's value hashed N times.
- R6: An iteration count of 0 stores the seed unchanged.
- R7: The result of chain k is written to output base + 8k through + 8k + 7, with hash word H0 first. A job writes exactly 8 words per chain and nothing else.
- R8: A chain count of 0 goes to DONE in the cycle after the start write, without any memory access.
- R9: DONE (status 4) holds until any write to register 0. That write returns the engine to idle (status 1).
- R10: A hash iteration takes 64 round cycles plus one final addition cycle. One chain takes 24 + 66·N cycles, so a job reaches DONE in cycle 1 + C·(24 + 66·N) after the start write.
- R11: mem_we is only high together with mem_req, and there is no memory access while idle or done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid the cycle after a read request |

## Verification
The hardest situation to reach is host traffic that lands in the middle of a long job. This means parameter writes and a second start that arrive while the engine is partway through a multi-chain hash, and DONE being held for many idle cycles before the acknowledge. The bench issues these writes right after the start command, while the first seed is still being fetched. After DONE it reads back the registers and counts every memory write. This shows that nothing restarted or moved. It also polls the status word every cycle to compare the exact DONE cycle with the latency formula.

// File: rtl/hce_pkg.sv
`timescale 1ns/1ps
package hce_pkg;

    typedef logic [31:0] word_t;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_LATCH, S_KICK, S_HASH, S_STORE, S_DONE
    } ctl_state_e;

    typedef enum logic [1:0] {
        C_IDLE, C_ROUND, C_FINAL
    } core_state_e;

    localparam logic [2:0] RA_CTRL  = 3'd0;
    localparam logic [2:0] RA_SRC   = 3'd1;
    localparam logic [2:0] RA_DST   = 3'd2;
    localparam logic [2:0] RA_CHN   = 3'd3;
    localparam logic [2:0] RA_ITER  = 3'd4;

    localparam int WORDS = 8;
    localparam int ROUNDS = 64;

    function automatic word_t rotr(input word_t x, input int n);
        return (x >> n) | (x << (32 - n));
    endfunction

    function automatic word_t big_s0(input word_t x);
        return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
    endfunction

    function automatic word_t big_s1(input word_t x);
        return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
    endfunction

    function automatic word_t sml_s0(input word_t x);
        return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
    endfunction

    function automatic word_t sml_s1(input word_t x);
        return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
    endfunction

    function automatic word_t iv_word(input int i);
        case (i)
            0: return 32'h6a09e667;
            1: return 32'hbb67ae85;
            2: return 32'h3c6ef372;
            3: return 32'ha54ff53a;
            4: return 32'h510e527f;
            5: return 32'h9b05688c;
            6: return 32'h1f83d9ab;
            default: return 32'h5be0cd19;
        endcase
    endfunction

    function automatic word_t round_k(input logic [5:0] t);
        case (t)
            6'd0:  return 32'h428a2f98;  6'd1:  return 32'h71374491;
            6'd2:  return 32'hb5c0fbcf;  6'd3:  return 32'he9b5dba5;
            6'd4:  return 32'h3956c25b;  6'd5:  return 32'h59f111f1;
            6'd6:  return 32'h923f82a4;  6'd7:  return 32'hab1c5ed5;
            6'd8:  return 32'hd807aa98;  6'd9:  return 32'h12835b01;
            6'd10: return 32'h243185be;  6'd11: return 32'h550c7dc3;
            6'd12: return 32'h72be5d74;  6'd13: return 32'h80deb1fe;
            6'd14: return 32'h9bdc06a7;  6'd15: return 32'hc19bf174;
            6'd16: return 32'he49b69c1;  6'd17: return 32'hefbe4786;
            6'd18: return 32'h0fc19dc6;  6'd19: return 32'h240ca1cc;
            6'd20: return 32'h2de92c6f;  6'd21: return 32'h4a7484aa;
            6'd22: return 32'h5cb0a9dc;  6'd23: return 32'h76f988da;
            6'd24: return 32'h983e5152;  6'd25: return 32'ha831c66d;
            6'd26: return 32'hb00327c8;  6'd27: return 32'hbf597fc7;
            6'd28: return 32'hc6e00bf3;  6'd29: return 32'hd5a79147;
            6'd30: return 32'h06ca6351;  6'd31: return 32'h14292967;
            6'd32: return 32'h27b70a85;  6'd33: return 32'h2e1b2138;
            6'd34: return 32'h4d2c6dfc;  6'd35: return 32'h53380d13;
            6'd36: return 32'h650a7354;  6'd37: return 32'h766a0abb;
            6'd38: return 32'h81c2c92e;  6'd39: return 32'h92722c85;
            6'd40: return 32'ha2bfe8a1;  6'd41: return 32'ha81a664b;
            6'd42: return 32'hc24b8b70;  6'd43: return 32'hc76c51a3;
            6'd44: return 32'hd192e819;  6'd45: return 32'hd6990624;
            6'd46: return 32'hf40e3585;  6'd47: return 32'h106aa070;
            6'd48: return 32'h19a4c116;  6'd49: return 32'h1e376c08;
            6'd50: return 32'h2748774c;  6'd51: return 32'h34b0bcb5;
            6'd52: return 32'h391c0cb3;  6'd53: return 32'h4ed8aa4a;
            6'd54: return 32'h5b9cca4f;  6'd55: return 32'h682e6ff3;
            6'd56: return 32'h748f82ee;  6'd57: return 32'h78a5636f;
            6'd58: return 32'h84c87814;  6'd59: return 32'h8cc70208;
            6'd60: return 32'h90befffa;  6'd61: return 32'ha4506ceb;
            6'd62: return 32'hbef9a3f7;  default: return 32'hc67178f2;
        endcase
    endfunction

endpackage

// File: rtl/hce_sha_core.sv
`timescale 1ns/1ps
module hce_sha_core
    import hce_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [255:0] msg,
    output logic         done,
    output logic [255:0] digest
);

    localparam int LAST_RND = ROUNDS - 1;

    core_state_e cs, cs_nx;
    logic [5:0]  rnd;
    word_t       v [WORDS];
    word_t       w [16];

    word_t t1, t2, w_new, ch, mj;

    always_comb begin
        ch    = (v[4] & v[5]) ^ (~v[4] & v[6]);
        mj    = (v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]);
        t1    = v[7] + big_s1(v[4]) + ch + round_k(rnd) + w[0];
        t2    = big_s0(v[0]) + mj;
        w_new = sml_s1(w[14]) + w[9] + sml_s0(w[1]) + w[0];
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs <= C_IDLE;
        else        cs <= cs_nx;
    end

    // next state
    always_comb begin
        cs_nx = cs;
        unique case (cs)
            C_IDLE:  if (start) cs_nx = C_ROUND;
            C_ROUND: if (rnd == 6'(LAST_RND)) cs_nx = C_FINAL;
            C_FINAL: cs_nx = C_IDLE;
            default: cs_nx = C_IDLE;
        endcase
    end

    // round datapath and message window
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rnd <= '0;
            for (int i = 0; i < WORDS; i++) v[i] <= '0;
            for (int i = 0; i < 16; i++)    w[i] <= '0;
        end else if (cs == C_IDLE && start) begin
            rnd <= '0;
            for (int i = 0; i < WORDS; i++) begin
                v[i] <= iv_word(i);
                w[i] <= msg[255 - 32*i -: 32];
            end
            w[8] <= 32'h8000_0000;
            for (int i = 9; i < 15; i++) w[i] <= '0;
            w[15] <= 32'd256;
        end else if (cs == C_ROUND) begin
            rnd  <= rnd + 6'd1;
            v[0] <= t1 + t2;
            v[1] <= v[0];
            v[2] <= v[1];
            v[3] <= v[2];
            v[4] <= v[3] + t1;
            v[5] <= v[4];
            v[6] <= v[5];
            v[7] <= v[6];
            for (int i = 0; i < 15; i++) w[i] <= w[i + 1];
            w[15] <= w_new;
        end
    end

    // outputs
    always_comb done = (cs == C_FINAL);

    for (genvar g = 0; g < WORDS; g++) begin : g_ff
        assign digest[255 - 32*g -: 32] = v[g] + iv_word(g);
    end

endmodule

// File: rtl/hce_regs.sv
`timescale 1ns/1ps
module hce_regs
    import hce_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int IW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          st_idle,
    input  logic          st_busy,
    input  logic          st_done,
    output logic          cmd_start,
    output logic          cmd_ack,
    output logic [AW-1:0] src_base,
    output logic [AW-1:0] dst_base,
    output logic [CW-1:0] n_chains,
    output logic [IW-1:0] n_iters
);

    logic ctrl_hit;
    assign ctrl_hit  = reg_wr && (reg_addr == RA_CTRL);
    assign cmd_start = ctrl_hit && reg_wdata[0];
    assign cmd_ack   = ctrl_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_base <= '0;
            dst_base <= '0;
            n_chains <= '0;
            n_iters  <= '0;
        end else if (reg_wr && st_idle) begin
            unique case (reg_addr)
                RA_SRC:  src_base <= AW'(reg_wdata);
                RA_DST:  dst_base <= AW'(reg_wdata);
                RA_CHN:  n_chains <= CW'(reg_wdata);
                RA_ITER: n_iters  <= IW'(reg_wdata);
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (reg_addr)
            RA_CTRL: reg_rdata = {29'd0, st_done, st_busy, st_idle};
            RA_SRC:  reg_rdata = 32'(src_base);
            RA_DST:  reg_rdata = 32'(dst_base);
            RA_CHN:  reg_rdata = 32'(n_chains);
            RA_ITER: reg_rdata = 32'(n_iters);
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/hce_ctrl.sv
`timescale 1ns/1ps
module hce_ctrl
    import hce_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int IW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_start,
    input  logic          cmd_ack,
    input  logic [AW-1:0] src_base,
    input  logic [AW-1:0] dst_base,
    input  logic [CW-1:0] n_chains,
    input  logic [IW-1:0] n_iters,
    output logic          core_start,
    output logic [255:0]  core_msg,
    input  logic          core_done,
    input  logic [255:0]  core_digest,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic          st_idle,
    output logic          st_busy,
    output logic          st_done
);

    localparam logic [2:0] LAST_WORD = 3'(WORDS - 1);

    ctl_state_e st, st_nx;
    logic [CW-1:0] chain;
    logic [2:0]    word;
    logic [IW-1:0] iter;
    word_t         vbuf [WORDS];

    logic last_chain, last_iter;
    assign last_chain = (chain == n_chains - CW'(1));
    assign last_iter  = (iter  == n_iters  - IW'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:  if (cmd_start) st_nx = (n_chains == '0) ? S_DONE : S_FETCH;
            S_FETCH: st_nx = S_LATCH;
            S_LATCH: if (word == LAST_WORD) st_nx = (n_iters == '0) ? S_STORE : S_KICK;
                     else                   st_nx = S_FETCH;
            S_KICK:  st_nx = S_HASH;
            S_HASH:  if (core_done) st_nx = last_iter ? S_STORE : S_KICK;
            S_STORE: if (word == LAST_WORD) st_nx = last_chain ? S_DONE : S_FETCH;
            S_DONE:  if (cmd_ack) st_nx = S_IDLE;
            default: st_nx = S_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
            word  <= '0;
            iter  <= '0;
            for (int i = 0; i < WORDS; i++) vbuf[i] <= '0;
        end else begin
            unique case (st)
                S_IDLE: begin
                    chain <= '0;
                    word  <= '0;
                end
                S_LATCH: begin
                    vbuf[word] <= mem_rdata;
                    word       <= word + 3'd1;
                    iter       <= '0;
                end
                S_HASH: if (core_done) begin
                    for (int i = 0; i < WORDS; i++) vbuf[i] <= core_digest[255 - 32*i -: 32];
                    iter <= iter + IW'(1);
                end
                S_STORE: begin
                    word <= word + 3'd1;
                    if (word == LAST_WORD) chain <= chain + CW'(1);
                end
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < WORDS; g++) begin : g_msg
        assign core_msg[255 - 32*g -: 32] = vbuf[g];
    end

    // outputs
    always_comb begin
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        core_start = 1'b0;
        st_idle    = 1'b0;
        st_busy    = 1'b0;
        st_done    = 1'b0;
        unique case (st)
            S_IDLE:  st_idle = 1'b1;
            S_FETCH: begin mem_req = 1'b1; st_busy = 1'b1; end
            S_STORE: begin mem_req = 1'b1; mem_we = 1'b1; st_busy = 1'b1; end
            S_KICK:  begin core_start = 1'b1; st_busy = 1'b1; end
            S_DONE:  st_done = 1'b1;
            default: st_busy = 1'b1;
        endcase
        mem_addr  = ((st == S_STORE) ? dst_base : src_base)
                    + AW'({chain, 3'b000}) + AW'(word);
        mem_wdata = vbuf[word];
    end

endmodule

// File: rtl/hash_chain_engine.sv
`timescale 1ns/1ps
module hash_chain_engine
    import hce_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int IW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata
);

    logic          st_idle, st_busy, st_done;
    logic          cmd_start, cmd_ack;
    logic [AW-1:0] src_base, dst_base;
    logic [CW-1:0] n_chains;
    logic [IW-1:0] n_iters;
    logic          core_start, core_done;
    logic [255:0]  core_msg, core_digest;

    hce_regs #(.AW(AW), .CW(CW), .IW(IW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .st_idle(st_idle), .st_busy(st_busy), .st_done(st_done),
        .cmd_start(cmd_start), .cmd_ack(cmd_ack),
        .src_base(src_base), .dst_base(dst_base),
        .n_chains(n_chains), .n_iters(n_iters)
    );

    hce_ctrl #(.AW(AW), .CW(CW), .IW(IW)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cmd_start(cmd_start), .cmd_ack(cmd_ack),
        .src_base(src_base), .dst_base(dst_base),
        .n_chains(n_chains), .n_iters(n_iters),
        .core_start(core_start), .core_msg(core_msg),
        .core_done(core_done), .core_digest(core_digest),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .st_idle(st_idle), .st_busy(st_busy), .st_done(st_done)
    );

    hce_sha_core u_core (
        .clk(clk), .rst_n(rst_n),
        .start(core_start), .msg(core_msg),
        .done(core_done), .digest(core_digest)
    );

endmodule

// File: rtl/hce_chk.sv
`timescale 1ns/1ps
module hce_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic [2:0]    reg_addr,
    input logic          wdata0,
    input logic          mem_req,
    input logic          mem_we,
    input logic          core_start,
    input logic          core_done,
    input logic          st_idle,
    input logic          st_done,
    input logic [AW-1:0] src_base,
    input logic [AW-1:0] dst_base
);

    logic [6:0] rnd_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               rnd_cnt <= '0;
        else if (core_start)                      rnd_cnt <= 7'd1;
        else if (rnd_cnt != '0 && rnd_cnt != '1)  rnd_cnt <= rnd_cnt + 7'd1;
    end

    // R10
    hash_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_done |-> rnd_cnt == 7'd65);

    // R11
    we_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req);

    // R11
    quiet_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_idle || st_done) |-> !mem_req);

    // R9
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_done && !(reg_wr && reg_addr == 3'd0)) |=> st_done);

    // R9
    ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_done && reg_wr && reg_addr == 3'd0) |=> st_idle);

    // R2
    param_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_idle |=> ($stable(src_base) && $stable(dst_base)));

    // R3
    start_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_idle && reg_wr && reg_addr == 3'd0 && wdata0) |=> !st_idle);

endmodule

bind hash_chain_engine hce_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .wdata0(reg_wdata[0]),
    .mem_req(mem_req), .mem_we(mem_we),
    .core_start(core_start), .core_done(core_done),
    .st_idle(st_idle), .st_done(st_done),
    .src_base(src_base), .dst_base(dst_base)
);

// File: tb/hash_chain_engine_test.sv
`timescale 1ns/1ps
module hash_chain_engine_test;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic [31:0]   mem_rdata = '0;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    logic [31:0] mem [1024];
    int wr_cnt = 0;
    int stray = 0;
    int win_lo = 0;
    int win_hi = 0;

    always #2.5 clk = ~clk;

    hash_chain_engine #(.AW(AW)) uut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req) begin
            if (mem_we) begin
                mem[mem_addr[9:0]] <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
                if (int'(mem_addr) < win_lo || int'(mem_addr) >= win_hi) stray <= stray + 1;
            end else begin
                mem_rdata <= mem[mem_addr[9:0]];
            end
        end
    end

    // ---------------- reference model ----------------
    localparam logic [31:0] KT [64] = '{
        32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
        32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
        32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
        32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
        32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
        32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
        32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
        32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2};
    localparam logic [31:0] HT [8] = '{
        32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
        32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};

    function automatic logic [31:0] rr(input logic [31:0] x, input int n);
        return (x >> n) | (x << (32 - n));
    endfunction

    function automatic logic [255:0] ref_sha(input logic [255:0] m);
        logic [31:0] w [64];
        logic [31:0] h [8];
        logic [31:0] t1, t2;
        logic [255:0] r;
        for (int i = 0; i < 8; i++) w[i] = m[255 - 32*i -: 32];
        w[8] = 32'h8000_0000;
        for (int i = 9; i < 15; i++) w[i] = 32'd0;
        w[15] = 32'd256;
        for (int i = 16; i < 64; i++)
            w[i] = (rr(w[i-2], 17) ^ rr(w[i-2], 19) ^ (w[i-2] >> 10)) + w[i-7]
                 + (rr(w[i-15], 7) ^ rr(w[i-15], 18) ^ (w[i-15] >> 3)) + w[i-16];
        for (int i = 0; i < 8; i++) h[i] = HT[i];
        for (int i = 0; i < 64; i++) begin
            t1 = h[7] + (rr(h[4], 6) ^ rr(h[4], 11) ^ rr(h[4], 25))
               + ((h[4] & h[5]) ^ (~h[4] & h[6])) + KT[i] + w[i];
            t2 = (rr(h[0], 2) ^ rr(h[0], 13) ^ rr(h[0], 22))
               + ((h[0] & h[1]) ^ (h[0] & h[2]) ^ (h[1] & h[2]));
            h[7] = h[6]; h[6] = h[5]; h[5] = h[4]; h[4] = h[3] + t1;
            h[3] = h[2]; h[2] = h[1]; h[1] = h[0]; h[0] = t1 + t2;
        end
        for (int i = 0; i < 8; i++) r[255 - 32*i -: 32] = h[i] + HT[i];
        return r;
    endfunction

    function automatic logic [255:0] ref_chain(input logic [255:0] s, input int n);
        logic [255:0] x = s;
        for (int i = 0; i < n; i++) x = ref_sha(x);
        return x;
    endfunction

    // ---------------- helpers ----------------
    task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    function automatic logic [255:0] mem_val(input int base);
        logic [255:0] r;
        for (int i = 0; i < 8; i++) r[255 - 32*i -: 32] = mem[base + i];
        return r;
    endfunction

    task automatic put_val(input int base, input logic [255:0] v);
        for (int i = 0; i < 8; i++) mem[base + i] = v[255 - 32*i -: 32];
    endtask

    task automatic setup(input int src, input int dst, input int ch, input int it);
        wr(3'd1, 32'(src));
        wr(3'd2, 32'(dst));
        wr(3'd3, 32'(ch));
        wr(3'd4, 32'(it));
        win_lo = dst;
        win_hi = dst + 8 * ch;
    endtask

    // returns cycles from start write to DONE (cycle 1 = first after write edge)
    task automatic wait_done(output int cycles);
        logic [31:0] s;
        cycles = 1;
        forever begin
            rd(3'd0, s);
            if (s[2]) break;
            if (cycles > 50000) begin
                n_chk++; n_bad++;
                $display("FAIL R9: DONE never reached, actual status %h expected 4", s);
                break;
            end
            @(negedge clk);
            cycles++;
        end
    endtask

    logic [31:0] lcg = 32'h1234_5678;
    function automatic logic [255:0] rnd_val();
        logic [255:0] r;
        for (int i = 0; i < 8; i++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            r[255 - 32*i -: 32] = lcg;
        end
        return r;
    endfunction

    // ---------------- scenarios ----------------
    task automatic t_reset();
        logic [31:0] d;
        rd(3'd0, d); check("R1 status", 256'(d), 256'(1));
        for (int a = 1; a <= 4; a++) begin
            rd(3'(a), d); check("R1 param", 256'(d), 256'(0));
        end
        check("R1 mem_req", 256'(mem_req), 256'(0));
    endtask

    task automatic t_regs();
        logic [31:0] d;
        setup(32'h40, 32'h80, 5, 9);
        rd(3'd1, d); check("R2 src", 256'(d), 256'(32'h40));
        rd(3'd2, d); check("R2 dst", 256'(d), 256'(32'h80));
        rd(3'd3, d); check("R2 chains", 256'(d), 256'(5));
        rd(3'd4, d); check("R2 iters", 256'(d), 256'(9));
        // R3: writing 0 to control does not start
        wr(3'd0, 32'd0);
        repeat (3) @(negedge clk);
        rd(3'd0, d); check("R3 no start on 0", 256'(d), 256'(1));
        check("R3 no mem access", 256'(wr_cnt), 256'(0));
    endtask

    task automatic t_zero_chain();
        int c;
        logic [31:0] d;
        int w0 = wr_cnt;
        setup(0, 32'h100, 0, 4);
        wr(3'd0, 32'd1);
        wait_done(c);
        check("R8 done cycle", 256'(c), 256'(1));
        check("R8 no writes", 256'(wr_cnt - w0), 256'(0));
        wr(3'd0, 32'd0);
        rd(3'd0, d); check("R9 ack to idle", 256'(d), 256'(1));
    endtask

    task automatic t_copy();
        int c;
        logic [255:0] s0, s1;
        int w0 = wr_cnt;
        s0 = rnd_val(); s1 = rnd_val();
        put_val(32'h10, s0); put_val(32'h18, s1);
        setup(32'h10, 32'h200, 2, 0);
        wr(3'd0, 32'd1);
        wait_done(c);
        check("R6 copy chain0", mem_val(32'h200), s0);
        check("R6 R4 copy chain1", mem_val(32'h208), s1);
        check("R10 copy latency", 256'(c), 256'(1 + 2 * 24));
        check("R7 write count", 256'(wr_cnt - w0), 256'(16));
        wr(3'd0, 32'd0);
    endtask

    task automatic t_known();
        int c;
        put_val(32'h20, 256'd0);
        setup(32'h20, 32'h240, 1, 1);
        wr(3'd0, 32'd1);
        wait_done(c);
        check("R5 known vector", mem_val(32'h240),
              256'h66687aadf862bd776c8fc18b8e9f8e20089714856ee233b3902a591d0d5f2925);
        check("R5 model agrees", mem_val(32'h240), ref_sha(256'd0));
        wr(3'd0, 32'd0);
    endtask

    task automatic t_chains_busy();
        int c;
        logic [31:0] d;
        logic [255:0] s [3];
        int w0 = wr_cnt;
        int st0 = stray;
        for (int k = 0; k < 3; k++) begin
            s[k] = rnd_val();
            put_val(32'h40 + 8 * k, s[k]);
        end
        setup(32'h40, 32'h300, 3, 2);
        wr(3'd0, 32'd1);
        rd(3'd0, d); check("R3 busy after start", 256'(d), 256'(2));
        wr(3'd1, 32'h3f0);     // ignored while busy
        wr(3'd3, 32'd7);
        wr(3'd0, 32'd1);       // start while busy: no effect
        wait_done(c);
        for (int k = 0; k < 3; k++)
            check("R5 R7 chain digest", mem_val(32'h300 + 8 * k), ref_chain(s[k], 2));
        check("R7 exact writes", 256'(wr_cnt - w0), 256'(24));
        check("R11 writes in window", 256'(stray - st0), 256'(0));
        rd(3'd1, d); check("R2 src locked", 256'(d), 256'(32'h40));
        rd(3'd3, d); check("R2 chains locked", 256'(d), 256'(3));
        repeat (10) @(negedge clk);
        rd(3'd0, d); check("R9 done holds", 256'(d), 256'(4));
        wr(3'd0, 32'd0);
        rd(3'd0, d); check("R9 ack", 256'(d), 256'(1));
    endtask

    task automatic t_latency();
        int c;
        logic [255:0] s;
        s = rnd_val();
        put_val(32'h80, s);
        setup(32'h80, 32'h380, 1, 3);
        wr(3'd0, 32'd1);
        wait_done(c);
        check("R10 job latency", 256'(c), 256'(1 + 24 + 66 * 3));
        check("R5 three iterations", mem_val(32'h380), ref_chain(s, 3));
        wr(3'd0, 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 32'hdead_0000 | 32'(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_zero_chain();
        t_copy();
        t_known();
        t_chains_busy();
        t_latency();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule